// File: doc/BRIEF.md
# FIFO Sticky Event Status Monitor

This block sits beside the transmit and receive FIFOs of a serial transceiver and turns their occupancy into a read-only status word of event flags. It does not hold FIFO data. It sees each FIFO only through its current count, the software access strobes, and the thresholds that software programs. Most flags are sticky. A flag records that an event has happened since the last status-clear command, and it stays set after the condition goes away.

The transmit side reports empty, full and a fill threshold. The receive side reports empty, full and two independent thresholds. Two access-error flags record a software write into a full transmit FIFO and a software read from an empty receive FIFO. These error flags survive the status-clear command, and only a software reset of the transceiver clears them. A lock bit mirrors the live transmit-lock input without any storage.

Top module: `fifo_evt_status_mon`

## Requirements
- R1: After `rst_n` is asserted, all 32 bits of `status` read 0. A cycle with `sw_rst` high also clears every stored flag on the next clock edge, and it takes priority over any set condition in that cycle.
- R2: Bit 0 (transmit empty) sets on the clock edge after a cycle in which `tx_cnt` is 0, and it stays set until it is cleared.
- R3: Bit 1 (transmit full) sets on the clock edge after a cycle in which `tx_cnt` equals DEPTH, and it stays set until it is cleared.
- R4: Bit 3 (receive empty) sets after a cycle with `rx_cnt` equal to 0. Bit 4 (receive full) sets after a cycle with `rx_cnt` equal to DEPTH. Both are sticky.
- R5: Bit 2 (transmit threshold) sets after a cycle in which `tx_cnt` is less than or equal to `tx_thr`. A threshold of 0 therefore sets the flag only when the count is 0.
- R6: Bit 5 sets after a cycle with `rx_cnt` greater than or equal to `rx_thr_a`. Bit 9 sets after a cycle with `rx_cnt` greater than or equal to `rx_thr_b`. The two flags are independent and both are sticky.
- R7: A cycle with `sta_clr` high clears bits 0 to 5 and bit 9 on the next edge. The exception is any flag whose condition is present in that same cycle: that flag stays set.
- R8: Bit 6 (transmit overflow) sets after a cycle in which `tx_wr` is high and `tx_cnt` equals DEPTH.
- R9: Bit 7 (receive underflow) sets after a cycle in which `rx_rd` is high and `rx_cnt` is 0.
- R10: Bits 6 and 7 are not affected by `sta_clr`. Only `sw_rst` or `rst_n` clears them.
- R11: Bit 8 equals `tx_lock` in the same cycle and is not stored.
- R12: Bits 31 to 10 always read 0. A strobe that is not an error (a write below full, or a read above empty) sets neither error bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset of the transceiver; clears all flags |
| sta_clr | input | 1 | Status-clear command; clears the sticky event flags |
| tx_cnt | input | CNT_W | Current transmit FIFO occupancy |
| rx_cnt | input | CNT_W | Current receive FIFO unread count |
| tx_thr | input | CNT_W | Transmit threshold |
| rx_thr_a | input | CNT_W | First receive threshold |
| rx_thr_b | input | CNT_W | Second receive threshold |
| tx_wr | input | 1 | Software write strobe to the transmit FIFO |
| rx_rd | input | 1 | Software read strobe from the receive FIFO |
| tx_lock | input | 1 | Live transmit FIFO lock state |
| status | output | 32 | Packed status word |

## Verification
On every cycle, the assertions check four properties: a stored flag is never lost unless a clear or reset occurs, a present set condition always wins over a clear, a software reset empties every flag, and the error flags survive a status clear. They also check that a full-write or an empty-read raises its error bit on the next edge, and that an empty transmit FIFO raises its flag. Only the bench's sweep can show the exact comparison semantics. That covers each threshold at every count, the inclusive edges at zero and at DEPTH, and the independence of the two receive thresholds. The same holds for the combined effect of a condition that disappears and a later clear, and for the live lock bit.

// File: rtl/fesm_pkg.sv
package fesm_pkg;
  localparam int STAT_W = 32;
  // software decodes these positions
  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_FULL  = 1;
  localparam int B_TX_THR   = 2;
  localparam int B_RX_EMPTY = 3;
  localparam int B_RX_FULL  = 4;
  localparam int B_RX_THR_A = 5;
  localparam int B_TX_OVF   = 6;
  localparam int B_RX_UDF   = 7;
  localparam int B_TX_LOCK  = 8;
  localparam int B_RX_THR_B = 9;
  localparam int USED_W     = 10;
  // clearable event vector index
  localparam int EVT_N      = 7;
  localparam int E_TX_EMPTY = 0;
  localparam int E_TX_FULL  = 1;
  localparam int E_TX_THR   = 2;
  localparam int E_RX_EMPTY = 3;
  localparam int E_RX_FULL  = 4;
  localparam int E_RX_THR_A = 5;
  localparam int E_RX_THR_B = 6;
  // error vector index
  localparam int ERR_N      = 2;
  localparam int X_TX_OVF   = 0;
  localparam int X_RX_UDF   = 1;
endpackage

// File: rtl/fesm_thr_cmp.sv
module fesm_thr_cmp #(
  parameter int CNT_W  = 4,
  parameter bit RISING = 1'b1
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] thr,
  output logic             hit
);
  generate
    if (RISING) begin : g_rise
      // receive side: unread data climbs toward the threshold
      assign hit = (cnt >= thr);
    end else begin : g_fall
      // transmit side: the FIFO drains down to the threshold
      assign hit = (cnt <= thr);
    end
  endgenerate
endmodule

// File: rtl/fesm_occ_decode.sv
module fesm_occ_decode #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter bit IS_TX = 1'b1
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             acc,
  output logic             empty,
  output logic             full,
  output logic             acc_err
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_FULL);

  generate
    if (IS_TX) begin : g_wr
      assign acc_err = acc & full;
    end else begin : g_rd
      assign acc_err = acc & empty;
    end
  endgenerate
endmodule

// File: rtl/fesm_sticky.sv
module fesm_sticky #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic         clr_en,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_d = q;
    if (sw_rst) begin
      q_d = '0;
    end else begin
      if (clr_en) q_d = '0;
      q_d = q_d | set;
    end
  end

  assign q_en = sw_rst | clr_en | (|set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && !clr_en) |=> ((q & $past(q)) == $past(q))); // R2

  AST_SET_WINS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst) |=> ((q & $past(set)) == $past(set))); // R7

  AST_SWRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (q == '0)); // R1
endmodule

// File: rtl/fifo_evt_status_mon.sv
module fifo_evt_status_mon
  import fesm_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             sta_clr,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [CNT_W-1:0] tx_thr,
  input  logic [CNT_W-1:0] rx_thr_a,
  input  logic [CNT_W-1:0] rx_thr_b,
  input  logic             tx_wr,
  input  logic             rx_rd,
  input  logic             tx_lock,
  output logic [31:0]      status
);
  logic             tx_empty, tx_full, tx_ovf_req;
  logic             rx_empty, rx_full, rx_udf_req;
  logic             tx_thr_hit, rx_thr_a_hit, rx_thr_b_hit;
  logic [EVT_N-1:0] evt_set, evt_q;
  logic [ERR_N-1:0] err_set, err_q;

  fesm_occ_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_tx_occ (
    .cnt(tx_cnt), .acc(tx_wr), .empty(tx_empty), .full(tx_full), .acc_err(tx_ovf_req));

  fesm_occ_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rx_occ (
    .cnt(rx_cnt), .acc(rx_rd), .empty(rx_empty), .full(rx_full), .acc_err(rx_udf_req));

  fesm_thr_cmp #(.CNT_W(CNT_W), .RISING(1'b0)) u_tx_thr (
    .cnt(tx_cnt), .thr(tx_thr), .hit(tx_thr_hit));
  fesm_thr_cmp #(.CNT_W(CNT_W), .RISING(1'b1)) u_rx_thr_a (
    .cnt(rx_cnt), .thr(rx_thr_a), .hit(rx_thr_a_hit));
  fesm_thr_cmp #(.CNT_W(CNT_W), .RISING(1'b1)) u_rx_thr_b (
    .cnt(rx_cnt), .thr(rx_thr_b), .hit(rx_thr_b_hit));

  always_comb begin
    evt_set             = '0;
    evt_set[E_TX_EMPTY] = tx_empty;
    evt_set[E_TX_FULL]  = tx_full;
    evt_set[E_TX_THR]   = tx_thr_hit;
    evt_set[E_RX_EMPTY] = rx_empty;
    evt_set[E_RX_FULL]  = rx_full;
    evt_set[E_RX_THR_A] = rx_thr_a_hit;
    evt_set[E_RX_THR_B] = rx_thr_b_hit;
    err_set             = '0;
    err_set[X_TX_OVF]   = tx_ovf_req;
    err_set[X_RX_UDF]   = rx_udf_req;
  end

  // event flags: cleared by the status command
  fesm_sticky #(.N(EVT_N)) u_evt (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .clr_en(sta_clr),
    .set(evt_set), .q(evt_q));

  // access errors: only a software reset clears them
  fesm_sticky #(.N(ERR_N)) u_err (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .clr_en(1'b0),
    .set(err_set), .q(err_q));

  always_comb begin
    status             = '0;
    status[B_TX_EMPTY] = evt_q[E_TX_EMPTY];
    status[B_TX_FULL]  = evt_q[E_TX_FULL];
    status[B_TX_THR]   = evt_q[E_TX_THR];
    status[B_RX_EMPTY] = evt_q[E_RX_EMPTY];
    status[B_RX_FULL]  = evt_q[E_RX_FULL];
    status[B_RX_THR_A] = evt_q[E_RX_THR_A];
    status[B_TX_OVF]   = err_q[X_TX_OVF];
    status[B_RX_UDF]   = err_q[X_RX_UDF];
    status[B_TX_LOCK]  = tx_lock;
    status[B_RX_THR_B] = evt_q[E_RX_THR_B];
  end

  AST_ERR_SURVIVES_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_clr && !sw_rst) |=> ((status[B_RX_UDF:B_TX_OVF] & $past(status[B_RX_UDF:B_TX_OVF]))
                              == $past(status[B_RX_UDF:B_TX_OVF]))); // R10

  AST_OVF_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_cnt == CNT_W'(DEPTH) && !sw_rst) |=> status[B_TX_OVF]); // R8

  AST_UDF_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_cnt == '0 && !sw_rst) |=> status[B_RX_UDF]); // R9

  AST_TX_EMPTY_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0 && !sw_rst) |=> status[B_TX_EMPTY]); // R2
endmodule

// File: tb/fifo_evt_status_mon_bench.sv
module fifo_evt_status_mon_bench;
  localparam int DEPTH = 4;
  localparam int CNT_W = 3;
  localparam int NV    = DEPTH + 1;

  logic             clk = 1'b0;
  logic             rst_n, sw_rst, sta_clr, tx_wr, rx_rd, tx_lock;
  logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_thr, rx_thr_a, rx_thr_b;
  logic [31:0]      status;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  fifo_evt_status_mon #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo_evt_status_mon (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .sta_clr(sta_clr),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_thr(tx_thr), .rx_thr_a(rx_thr_a),
    .rx_thr_b(rx_thr_b), .tx_wr(tx_wr), .rx_rd(rx_rd), .tx_lock(tx_lock),
    .status(status));

  // expected event bits from the requirement rules (R2 R3 R4 R5 R6)
  function automatic logic [31:0] evt_word(int a, int t, int b, int u, int v);
    logic [31:0] w;
    w    = '0;
    w[0] = (a == 0);
    w[1] = (a == DEPTH);
    w[2] = (a <= t);
    w[3] = (b == 0);
    w[4] = (b == DEPTH);
    w[5] = (b >= u);
    w[9] = (b >= v);
    return w;
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FIFO check FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(int a, int t, int b, int u, int v);
    tx_cnt   = CNT_W'(a);
    tx_thr   = CNT_W'(t);
    rx_cnt   = CNT_W'(b);
    rx_thr_a = CNT_W'(u);
    rx_thr_b = CNT_W'(v);
  endtask

  initial begin
    rst_n = 1'b0; sw_rst = 1'b0; sta_clr = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0;
    tx_lock = 1'b0;
    drive(2, 0, 2, 4, 4);
    #1;
    chk(status, 32'h0, "R1 async reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 live lock bit, upper bits zero (R12)
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    tx_lock = 1'b1;
    #1;
    chk(status & 32'h0000_0100, 32'h0000_0100, "R11 lock high");
    chk(status & 32'hFFFF_FC00, 32'h0, "R12 upper zero");
    @(negedge clk);
    tx_lock = 1'b0;
    #1;
    chk(status & 32'h0000_0100, 32'h0, "R11 lock low");

    // exhaustive sweep of counts and thresholds
    for (int a = 0; a < NV; a++)
      for (int t = 0; t < NV; t++)
        for (int b = 0; b < NV; b++)
          for (int u = 0; u < NV; u++)
            for (int v = 0; v < NV; v++) begin
              int a2, b2, a3, b3;
              logic [31:0] e1, e2, e3;
              a2 = (a + 2) % NV; b2 = (b + 3) % NV;
              a3 = (a + 4) % NV; b3 = (b + 1) % NV;
              e1 = evt_word(a, t, b, u, v);
              e2 = evt_word(a2, t, b2, u, v);
              e3 = evt_word(a3, t, b3, u, v);
              @(negedge clk);
              drive(a, t, b, u, v);
              sw_rst = 1'b1;
              @(negedge clk);
              sw_rst = 1'b0;
              if (a == 0 && t == 0 && b == 0 && u == 0 && v == 0)
                chk(status, 32'h0, "R1 sw reset wins over set");
              @(negedge clk);
              chk(status, e1, "R2/R3/R4/R5/R6 flags from levels");
              sta_clr = 1'b1;
              @(negedge clk);
              chk(status, e1, "R7 present condition survives clear");
              sta_clr = 1'b0;
              drive(a2, t, b2, u, v);
              @(negedge clk);
              chk(status, e1 | e2, "R2 R4 sticky after condition moves");
              drive(a3, t, b3, u, v);
              sta_clr = 1'b1;
              @(negedge clk);
              sta_clr = 1'b0;
              chk(status, e3, "R7 clear keeps only present events");
            end

    // access errors at every count
    for (int c = 0; c < NV; c++) begin
      logic [31:0] ee;
      ee    = '0;
      ee[6] = (c == DEPTH);
      ee[7] = (c == 0);
      @(negedge clk);
      drive(c, 0, c, DEPTH, DEPTH);
      sw_rst = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0;
      tx_wr = 1'b1; rx_rd = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0; rx_rd = 1'b0;
      chk(status & 32'hC0, ee, "R8 R9 R12 error on bad access only");
      sta_clr = 1'b1;
      @(negedge clk);
      sta_clr = 1'b0;
      chk(status & 32'hC0, ee, "R10 errors survive status clear");
      @(negedge clk);
      chk(status & 32'hC0, ee, "R10 errors held");
      sw_rst = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0;
      chk(status & 32'hC0, 32'h0, "R10 R1 sw reset clears errors");
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FIFO check FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule